// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block gathers ninety-six single-cycle event pulses from peripherals and holds each one in a sticky status bit. The status bits are packed into three 32-bit words. Three independent mask banks each choose a subset of those events and drive one level-sensitive processor interrupt line. Line A is driven by bank 0 and has the highest priority. Line B comes from bank 1 and line C from bank 2.

Software reaches the block through a plain 32-bit register port with an address, a write enable, write data and registered read data. It clears a pending event by writing a one to its status bit. For fast dispatch, each line also has a read-only register that gives the lowest-numbered event that is both pending and enabled for that line. Software can therefore jump straight to a handler without scanning the three words.

Top module: `evt_agg`

## Requirements
- R1: Event number n (0 to 95) is captured in status word n/32 at bit n mod 32. The status words read at byte offsets 0x00, 0x04 and 0x08. A pulse on `evt_in[n]` sets the bit at the clock edge where it is sampled.
- R2: A write to a status word clears every bit that is one in the write data. Bits written as zero keep their value, and status bits never clear without such a write.
- R3: When an event pulse and a clearing write hit the same status bit at the same edge, the bit stays set.
- R4: Mask word w of bank g reads and writes at byte offset 0x10·(g+1) + 4·w, for g and w in 0..2. A mask bit of one enables the matching event onto that bank's line.
- R5: `irq[g]` is registered. It is high one edge after any bit of (status AND mask of bank g) is one, and it stays high until all such bits are cleared or masked. `irq[0]` is line A, `irq[1]` is line B and `irq[2]` is line C.
- R6: The index register of bank g sits at offset 0x40 + 4·g. Bits [6:0] hold the lowest event number whose status and bank-g mask bits are both one, bit 7 is one when such an event exists, and bits [31:8] read zero. When bit 7 is zero, bits [6:0] are zero.
- R7: After reset, all status words, mask words, index registers and interrupt lines are zero.
- R8: A read of any other offset returns zero, and that includes offsets whose low two bits are not zero. Writes to such offsets and to the index registers change nothing.
- R9: `rd_data` is registered. It shows the register selected by `addr` at a rising edge from that edge onwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 96 | Single-cycle event pulses, bit n is event n |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 3 | Level interrupt lines A, B, C |

## Verification
If a status bit is stuck or lost, the next read of its word shows it one edge later. The index registers and the interrupt lines show it as well, because the bench enables each event alone on one bank and compares the whole register map after every step. A wrong mask decode shows as a mask word that reads back wrong, or as an interrupt on the wrong line, within two edges of the event. A wrong priority order shows in the index register once several events are pending together and then cleared one by one.

// File: rtl/evt_agg_pkg.sv
`timescale 1ns/1ps
package evt_agg_pkg;
  // Register window layout: 16-byte blocks, four 32-bit slots per block
  localparam int BLK_STATUS = 0;  // block holding the status words
  localparam int BLK_MASK0  = 1;  // first mask bank block
  localparam int SLOT_LSB   = 2;  // byte address bit where the slot field starts
  localparam int BLK_LSB    = 4;  // byte address bit where the block field starts
endpackage

// File: rtl/evt_lowest_enc.sv
`timescale 1ns/1ps
// Lowest-set-bit encoder: returns the position of the least significant one
module evt_lowest_enc #(
  parameter int N     = 96,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] pos
);
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        pos   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/evt_status_bank.sv
`timescale 1ns/1ps
// Sticky event status words with write-one-to-clear; an incoming event beats a clear
module evt_status_bank #(
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32,
  localparam int NUM_EVT  = NUM_WORDS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_EVT-1:0]   evt_in,
  input  logic [NUM_WORDS-1:0] clr_sel,
  input  logic [WORD_W-1:0]    wdata,
  output logic [NUM_EVT-1:0]   status
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] clr_bits;

    assign clr_bits = clr_sel[w] ? wdata : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else begin
        word_q <= (word_q & ~clr_bits) | evt_in[w*WORD_W +: WORD_W];
      end
    end

    assign status[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/evt_mask_group.sv
`timescale 1ns/1ps
// One mask bank: mask words, registered level interrupt and lowest pending index
module evt_mask_group #(
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32,
  localparam int NUM_EVT  = NUM_WORDS * WORD_W,
  localparam int IDX_W    = $clog2(NUM_EVT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WORDS-1:0] wr_sel,
  input  logic [WORD_W-1:0]    wdata,
  input  logic [NUM_EVT-1:0]   status,
  output logic [NUM_EVT-1:0]   mask,
  output logic                 irq,
  output logic                 idx_valid,
  output logic [IDX_W-1:0]     idx_num
);
  logic [NUM_EVT-1:0] masked;
  logic               irq_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] mask_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q <= '0;
      end else if (wr_sel[w]) begin
        mask_q <= wdata;
      end
    end

    assign mask[w*WORD_W +: WORD_W] = mask_q;
  end

  assign masked = status & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |masked;
    end
  end

  assign irq = irq_q;

  evt_lowest_enc #(
    .N     (NUM_EVT),
    .IDX_W (IDX_W)
  ) u_enc (
    .vec   (masked),
    .found (idx_valid),
    .pos   (idx_num)
  );
endmodule

// File: rtl/evt_agg.sv
`timescale 1ns/1ps
// Masked event interrupt aggregator: shared status, parallel mask banks, index registers
module evt_agg
  import evt_agg_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32,
  parameter int NUM_LINES = 3,
  parameter int ADDR_W    = 8,
  localparam int NUM_EVT  = NUM_WORDS * WORD_W,
  localparam int IDX_W    = $clog2(NUM_EVT),
  localparam int BLK_W    = ADDR_W - BLK_LSB,
  localparam int BLK_IDX  = BLK_MASK0 + NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_EVT-1:0]   evt_in,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rd_data,
  output logic [NUM_LINES-1:0] irq
);
  // Address decode
  logic                  aligned;
  logic [31:0]           blk_i;
  logic [31:0]           slot_i;
  logic                  stat_hit;
  logic [NUM_WORDS-1:0]  stat_clr;

  assign aligned  = (addr[SLOT_LSB-1:0] == '0);
  assign blk_i    = 32'(addr[ADDR_W-1:BLK_LSB]);
  assign slot_i   = 32'(addr[BLK_LSB-1:SLOT_LSB]);
  assign stat_hit = aligned && (blk_i == BLK_STATUS) && (slot_i < NUM_WORDS);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_clr
    assign stat_clr[w] = wr_en && stat_hit && (slot_i == w);
  end

  // Shared status
  logic [NUM_EVT-1:0] status_q;

  evt_status_bank #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W)
  ) u_status (
    .clk     (clk),
    .rst     (rst),
    .evt_in  (evt_in),
    .clr_sel (stat_clr),
    .wdata   (wdata),
    .status  (status_q)
  );

  // Mask banks, one per interrupt line
  logic [NUM_LINES-1:0][NUM_EVT-1:0] mask_all;
  logic [NUM_LINES-1:0]              idx_valid;
  logic [NUM_LINES-1:0][IDX_W-1:0]   idx_num;
  logic [NUM_LINES-1:0]              mask_hit;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [NUM_WORDS-1:0] mask_wr;

    assign mask_hit[g] = aligned && (blk_i == BLK_MASK0 + g) && (slot_i < NUM_WORDS);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_sel
      assign mask_wr[w] = wr_en && mask_hit[g] && (slot_i == w);
    end

    evt_mask_group #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W)
    ) u_group (
      .clk       (clk),
      .rst       (rst),
      .wr_sel    (mask_wr),
      .wdata     (wdata),
      .status    (status_q),
      .mask      (mask_all[g]),
      .irq       (irq[g]),
      .idx_valid (idx_valid[g]),
      .idx_num   (idx_num[g])
    );
  end

  // Read mux, registered
  logic [WORD_W-1:0] rd_next;
  logic              idx_hit;

  assign idx_hit = aligned && (blk_i == BLK_IDX) && (slot_i < NUM_LINES);

  always_comb begin
    rd_next = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (stat_hit && (slot_i == w)) begin
        rd_next = status_q[w*WORD_W +: WORD_W];
      end
    end
    for (int g = 0; g < NUM_LINES; g++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (mask_hit[g] && (slot_i == w)) begin
          rd_next = mask_all[g][w*WORD_W +: WORD_W];
        end
      end
      if (idx_hit && (slot_i == g)) begin
        rd_next = WORD_W'({idx_valid[g], idx_num[g]});
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/evt_agg_chk.sv
`timescale 1ns/1ps
// Temporal checks for the aggregator, attached by bind
module evt_agg_chk #(
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32,
  parameter int NUM_LINES = 3,
  localparam int NUM_EVT  = NUM_WORDS * WORD_W
) (
  input logic                              clk,
  input logic                              rst,
  input logic [NUM_EVT-1:0]                evt_in,
  input logic                              wr_en,
  input logic [NUM_EVT-1:0]                status,
  input logic [NUM_LINES-1:0][NUM_EVT-1:0] mask_all,
  input logic [NUM_LINES-1:0]              irq
);
  // R1 and R3: a pulsed event is always held after the edge, even against a clear
  p_event_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (evt_in != '0) |=> ((status & $past(evt_in)) == $past(evt_in)));

  // R2: without a write no status bit falls
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((status & $past(status)) == $past(status)));

  // R4: masks only move on a write
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask_all));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    // R5: line rises after an enabled pending event
    p_irq_rise_r5: assert property (@(posedge clk) disable iff (rst)
      (|(status & mask_all[g])) |=> irq[g]);
    // R5: line drops once nothing enabled is pending
    p_irq_fall_r5: assert property (@(posedge clk) disable iff (rst)
      !(|(status & mask_all[g])) |=> !irq[g]);
  end
endmodule

bind evt_agg evt_agg_chk #(
  .NUM_WORDS (NUM_WORDS),
  .WORD_W    (WORD_W),
  .NUM_LINES (NUM_LINES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .evt_in   (evt_in),
  .wr_en    (wr_en),
  .status   (status_q),
  .mask_all (mask_all),
  .irq      (irq)
);

// File: tb/test_evt_agg.sv
`timescale 1ns/1ps
module test_evt_agg;
  localparam int NE = 96;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] evt_in = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rd_data;
  logic [2:0]    irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model
  logic [NE-1:0] m_stat = '0;
  logic [NE-1:0] m_mask [3];

  evt_agg i_evt_agg (
    .clk(clk), .rst(rst), .evt_in(evt_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    #1;
    d = rd_data;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  // Apply a register write to the model by arithmetic decode
  task automatic model_wr(logic [7:0] a, logic [31:0] d);
    int ai;
    ai = int'(a);
    if (ai % 4 == 0) begin
      if (ai < 12) begin
        m_stat[(ai/4)*32 +: 32] = m_stat[(ai/4)*32 +: 32] & ~d;
      end else if (ai >= 16 && ai < 64 && (ai % 16) < 12) begin
        m_mask[ai/16 - 1][((ai % 16)/4)*32 +: 32] = d;
      end
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic pulse(logic [NE-1:0] v);
    @(negedge clk);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
    m_stat = m_stat | v;
  endtask

  function automatic logic [31:0] exp_idx(int g);
    logic [NE-1:0] mv;
    mv = m_stat & m_mask[g];
    for (int i = 0; i < NE; i++) begin
      if (mv[i]) return 32'h80 | 32'(i);
    end
    return 32'h0;
  endfunction

  // Compare the full register map and the lines against the model
  task automatic verify_all(string req);
    for (int w = 0; w < 3; w++) rd_chk({req, " R1 status"}, 8'(4*w), m_stat[w*32 +: 32]);
    for (int g = 0; g < 3; g++)
      for (int w = 0; w < 3; w++)
        rd_chk({req, " R4 mask"}, 8'(16*(g+1) + 4*w), m_mask[g][w*32 +: 32]);
    for (int g = 0; g < 3; g++) rd_chk({req, " R6 index"}, 8'(64 + 4*g), exp_idx(g));
    for (int g = 0; g < 3; g++) check({req, " R5 irq"}, 32'(irq[g]), 32'(|(m_stat & m_mask[g])));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int g = 0; g < 3; g++) m_mask[g] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: everything zero after reset
    verify_all("R7");

    // R9: read data changes only at the edge after addr moves
    wr(8'h14, 32'hA5A5_0001);
    rd_chk("R9 first", 8'h14, 32'hA5A5_0001);
    @(negedge clk);
    addr = 8'h00;
    #0.5;
    check("R9 held before edge", rd_data, 32'hA5A5_0001);
    @(posedge clk);
    #1;
    check("R9 after edge", rd_data, 32'h0);
    wr(8'h14, 32'h0);

    // R1 R2 R4 R5 R6: each event alone, routed to one bank
    for (int n = 0; n < NE; n++) begin
      int g;
      logic [NE-1:0] v;
      g = n % 3;
      v = '0;
      v[n] = 1'b1;
      wr(8'(16*(g+1) + 4*(n/32)), 32'(1) << (n % 32));
      pulse(v);
      @(negedge clk);
      verify_all("R1");
      wr(8'(4*(n/32)), ~(32'(1) << (n % 32)));   // R2: zeros keep the bit
      verify_all("R2 zero write");
      wr(8'(4*(n/32)), 32'(1) << (n % 32));      // R2: one clears it
      @(negedge clk);
      verify_all("R2 clear");
      wr(8'(16*(g+1) + 4*(n/32)), 32'h0);
    end

    // R6: priority across words with several events pending
    for (int w = 0; w < 3; w++) wr(8'(32 + 4*w), 32'hFFFF_FFFF);
    begin
      logic [NE-1:0] v;
      v = '0;
      v[95] = 1'b1; v[40] = 1'b1; v[33] = 1'b1;
      pulse(v);
    end
    @(negedge clk);
    verify_all("R6 three pending");
    check("R6 lowest", exp_idx(1), 32'h80 | 32'd33);
    wr(8'h04, 32'h2);
    @(negedge clk);
    verify_all("R6 after 33");
    wr(8'h04, 32'h100);
    @(negedge clk);
    verify_all("R6 after 40");
    wr(8'h08, 32'h8000_0000);
    @(negedge clk);
    verify_all("R6 none");

    // R5: masking a pending event drops the line while status holds
    begin
      logic [NE-1:0] v;
      v = '0;
      v[50] = 1'b1;
      pulse(v);
      @(negedge clk);
      verify_all("R5 pending");
      wr(8'h24, 32'h0);
      @(negedge clk);
      verify_all("R5 masked");
      wr(8'h04, 32'h0004_0000);
    end
    for (int w = 0; w < 3; w++) wr(8'(32 + 4*w), 32'h0);

    // R3: event and clear of the same bit at one edge
    wr(8'h10, 32'h0000_0400);
    begin
      logic [NE-1:0] v;
      v = '0;
      v[10] = 1'b1;
      pulse(v);
      @(negedge clk);
      evt_in = v; wr_en = 1'b1; addr = 8'h00; wdata = 32'h0000_0400;
      @(negedge clk);
      evt_in = '0; wr_en = 1'b0;
      rd_chk("R3 set wins", 8'h00, 32'h0000_0400);
      check("R3 line A", 32'(irq[0]), 32'h1);
      wr(8'h00, 32'h0000_0400);
      @(negedge clk);
      verify_all("R3 cleared");
    end

    // R8: unmapped and read-only offsets
    wr(8'h10, 32'hF0F0_1234);
    pulse(96'h1 << 4);
    @(negedge clk);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    verify_all("R8 ignored writes");
    rd_chk("R8 0x0C", 8'h0C, 32'h0);
    rd_chk("R8 0x1C", 8'h1C, 32'h0);
    rd_chk("R8 0x4C", 8'h4C, 32'h0);
    rd_chk("R8 0x11", 8'h11, 32'h0);
    rd_chk("R8 0x50", 8'h50, 32'h0);
    rd_chk("R8 0xFC", 8'hFC, 32'h0);
    rd(8'h40, d);
    check("R8 index readable", d, 32'h84);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule